// File: doc/BRIEF.md
# DDR Bit-Pair Sample Deinterleaver

This block sits behind the input delay and double-data-rate input registers of a wide parallel ADC port. The converter drives each sample as a 16-bit word split over 8 lanes; every lane launches one bit on the rising edge of the sample clock and a second bit on the falling edge. After the input registers, each lane shows up in the sample clock domain as a pair of single-bit outputs: the bit captured on the rising edge and the bit captured on the falling edge. The block puts the two halves of each sample into the same clock cycle, interleaves the bit pairs into the original word and registers it with a valid flag.

The input registers can present the two halves in one of two ways, chosen by the `FALL_LAG` parameter. With `FALL_LAG = 1` (the default), the rising-edge half shows up one cycle before the falling-edge half, and the block holds it back one cycle. With `FALL_LAG = 0`, both halves arrive in the same cycle. In both cases `in_valid` marks the cycle in which the falling-edge half is present, which is the cycle that completes the sample. The whole path runs on the ADC's forwarded clock, so every lane is in the same phase and no per-lane alignment is needed.

Top module: `ddr_deint_top`

## Requirements
- R1: While the internal reset is active, `out_word` reads 0 and `out_valid` reads 0. Driving `rst_n` low clears both at once, without waiting for a clock edge. Release passes through a two-flop synchronizer, so inputs are ignored for the first two rising edges after `rst_n` goes high.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and it is low otherwise.
- R3: In a captured word, bit 2k+1 holds lane k's rising-edge bit (`lane_rise[k]`), for every lane k from 0 to 7.
- R4: In a captured word, bit 2k holds lane k's falling-edge bit (`lane_fall[k]`), taken in the cycle in which `in_valid` is high.
- R5: With `FALL_LAG = 1`, the rising-edge bits in a captured word are the values `lane_rise` had one cycle before the `in_valid` cycle. With `FALL_LAG = 0`, they are the values `lane_rise` has in the `in_valid` cycle itself.
- R6: A cycle with `in_valid` low leaves `out_word` unchanged, whatever the lanes carry in that cycle.
- R7: Samples on consecutive cycles are each delivered, one per cycle, with no gap and none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock forwarded from the ADC |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | High in the cycle that carries the falling-edge half of a sample |
| lane_rise | input | 8 | Rising-edge capture of each lane; bit k belongs to lane k |
| lane_fall | input | 8 | Falling-edge capture of each lane; bit k belongs to lane k |
| out_word | output | 16 | Rebuilt sample word |
| out_valid | output | 1 | High for one cycle when `out_word` holds a new sample |

## Verification
Two things can happen on the same rising edge: the retime register loads the rising half of the next sample, and the output register loads the current sample, which needs the rising half that register is holding now. The table sends valid samples back to back with a new rising pattern in every cycle. An error by one cycle in the retime path would therefore put a neighbouring sample's bits into the word. Each word is compared with a bench model that pairs the previous cycle's rising bits with the current falling bits. A second instance with no lag is compared with the current cycle's bits instead.

// File: rtl/ddr_deint_pkg.sv
package ddr_deint_pkg;
  localparam int unsigned DEF_LANES = 8;

  // bit positions of a lane pair inside the rebuilt word
  function automatic int unsigned rise_pos(input int unsigned lane);
    return 2 * lane + 1;
  endfunction

  function automatic int unsigned fall_pos(input int unsigned lane);
    return 2 * lane;
  endfunction
endpackage

// File: rtl/ddr_deint_rst_sync.sv
module ddr_deint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ddr_deint_lane_align.sv
module ddr_deint_lane_align #(
  parameter int unsigned LANES    = ddr_deint_pkg::DEF_LANES,
  parameter int unsigned FALL_LAG = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] rise_in,
  input  logic [LANES-1:0] fall_in,
  output logic [LANES-1:0] rise_out,
  output logic [LANES-1:0] fall_out
);
  assign fall_out = fall_in;

  generate
    if (FALL_LAG != 0) begin : g_lag
      logic [LANES-1:0] rise_q;
      logic [LANES-1:0] rise_d;
      logic             hold_en;

      assign hold_en = 1'b1;

      always_comb begin
        rise_d = rise_q;
        if (hold_en) rise_d = rise_in;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
      end

      assign rise_out = rise_q;
    end else begin : g_nolag
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign rise_out = rise_in;
    end
  endgenerate
endmodule

// File: rtl/ddr_deint_interleave.sv
module ddr_deint_interleave #(
  parameter int unsigned LANES = ddr_deint_pkg::DEF_LANES,
  localparam int unsigned WORD_W = 2 * LANES
) (
  input  logic [LANES-1:0]  rise_bits,
  input  logic [LANES-1:0]  fall_bits,
  output logic [WORD_W-1:0] word
);
  import ddr_deint_pkg::*;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_pair
      assign word[rise_pos(k)] = rise_bits[k];
      assign word[fall_pos(k)] = fall_bits[k];
    end
  endgenerate
endmodule

// File: rtl/ddr_deint_top.sv
module ddr_deint_top #(
  parameter int unsigned LANES    = ddr_deint_pkg::DEF_LANES,
  parameter int unsigned FALL_LAG = 1,
  localparam int unsigned WORD_W  = 2 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [LANES-1:0]  lane_rise,
  input  logic [LANES-1:0]  lane_fall,
  output logic [WORD_W-1:0] out_word,
  output logic              out_valid
);
  logic              rst_sync_n;
  logic [LANES-1:0]  rise_al;
  logic [LANES-1:0]  fall_al;
  logic [WORD_W-1:0] word_comb;
  logic [WORD_W-1:0] word_d;
  logic [WORD_W-1:0] word_q;
  logic              valid_d;
  logic              valid_q;
  logic              in_valid_g;

  ddr_deint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ddr_deint_lane_align #(
    .LANES    (LANES),
    .FALL_LAG (FALL_LAG)
  ) u_align (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rise_in  (lane_rise),
    .fall_in  (lane_fall),
    .rise_out (rise_al),
    .fall_out (fall_al)
  );

  ddr_deint_interleave #(
    .LANES (LANES)
  ) u_ilv (
    .rise_bits (rise_al),
    .fall_bits (fall_al),
    .word      (word_comb)
  );

  assign in_valid_g = in_valid & rst_sync_n;

  always_comb begin
    word_d  = word_q;
    valid_d = in_valid_g;
    if (in_valid_g) word_d = word_comb;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign out_word  = word_q;
  assign out_valid = valid_q;
endmodule

// File: rtl/ddr_deint_checker.sv
module ddr_deint_checker #(
  parameter int unsigned LANES    = 8,
  parameter int unsigned FALL_LAG = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [LANES-1:0]  lane_rise,
  input logic [LANES-1:0]  lane_fall,
  input logic [2*LANES-1:0] out_word,
  input logic              out_valid
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (out_valid == 1'b0 && out_word == '0)
        else $error("R1 outputs not cleared in reset");
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q != 2'd0) |-> (out_valid == $past(in_valid)));

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

  assert_fall_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[0] == $past(lane_fall[0])));

  assert_fall_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_word[2*LANES-2] == $past(lane_fall[LANES-1])));

  generate
    if (FALL_LAG != 0) begin : g_lag_chk
      assert_rise_lag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && age_q >= 2'd1) |=> (out_word[1] == $past(lane_rise[0], 2)));
    end else begin : g_nolag_chk
      assert_rise_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_word[1] == $past(lane_rise[0])));
    end
  endgenerate
endmodule

bind ddr_deint_top ddr_deint_checker #(
  .LANES    (LANES),
  .FALL_LAG (FALL_LAG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .lane_rise (lane_rise),
  .lane_fall (lane_fall),
  .out_word  (out_word),
  .out_valid (out_valid)
);

// File: tb/tb_ddr_deint_top.sv
`timescale 1ns/1ps
module tb_ddr_deint_top;
  localparam int LANES = 8;
  localparam int NVEC  = 14;

  // each entry: {valid, rise[7:0], fall[7:0]}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'hA5, 8'h3C},
    {1'b1, 8'hFF, 8'h00},
    {1'b1, 8'h00, 8'hFF},
    {1'b1, 8'h01, 8'h80},
    {1'b0, 8'h5A, 8'hC3},
    {1'b0, 8'hFF, 8'hFF},
    {1'b1, 8'h80, 8'h01},
    {1'b1, 8'h12, 8'h34},
    {1'b0, 8'h00, 8'h00},
    {1'b1, 8'hFF, 8'hFF},
    {1'b1, 8'h55, 8'hAA},
    {1'b1, 8'hAA, 8'h55},
    {1'b0, 8'h77, 8'h99},
    {1'b1, 8'h0F, 8'hF0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [LANES-1:0] lane_rise = '0;
  logic [LANES-1:0] lane_fall = '0;
  logic [2*LANES-1:0] out_word, out_word0;
  logic out_valid, out_valid0;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  logic [2*LANES-1:0] exp_w1, exp_w0;
  logic               exp_v;
  logic [LANES-1:0]   prev_rise;

  always #2.5 clk = ~clk;

  ddr_deint_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .lane_rise(lane_rise), .lane_fall(lane_fall),
    .out_word(out_word), .out_valid(out_valid));

  ddr_deint_top #(.FALL_LAG(0)) dut0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .lane_rise(lane_rise), .lane_fall(lane_fall),
    .out_word(out_word0), .out_valid(out_valid0));

  function automatic logic [2*LANES-1:0] pairup(input logic [LANES-1:0] r,
                                                input logic [LANES-1:0] f);
    logic [2*LANES-1:0] w;
    for (int k = 0; k < LANES; k++) begin
      w[2*k+1] = r[k];
      w[2*k]   = f[k];
    end
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare outputs from the previous step, then drive a new cycle
  task automatic step(input string tag, input logic v,
                      input logic [LANES-1:0] r, input logic [LANES-1:0] f);
    @(negedge clk);
    check({tag, " R2 valid lag"}, {31'd0, out_valid}, {31'd0, exp_v});
    check({tag, " R3/R4/R5/R6 word"}, {16'd0, out_word}, {16'd0, exp_w1});
    check({tag, " R3 no-lag word"}, {16'd0, out_word0}, {16'd0, exp_w0});
    if (v) begin
      exp_w1 = pairup(prev_rise, f);
      exp_w0 = pairup(r, f);
    end
    exp_v     = v;
    prev_rise = r;
    in_valid  = v;
    lane_rise = r;
    lane_fall = f;
  endtask

  task automatic clear_model();
    exp_w1 = '0; exp_w0 = '0; exp_v = 1'b0; prev_rise = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", {16'd0, out_word}, 32'd0);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    // two synchronizer edges with idle inputs
    step("R1 idle", 1'b0, '0, '0);
    step("R1 idle", 1'b0, '0, '0);
    step("R1 idle", 1'b0, '0, '0);

    // table walk: back-to-back samples (R7), idle holds (R6)
    for (int i = 0; i < NVEC; i++)
      step("R7 table", VEC[i][16], VEC[i][15:8], VEC[i][7:0]);
    step("R6 idle", 1'b0, 8'hC3, 8'h3C);
    step("R6 idle", 1'b0, 8'h00, 8'h00);

    // single-lane corners for R3/R4
    step("R4 lane7", 1'b1, 8'h00, 8'h80);
    step("R3 prime", 1'b0, 8'h40, 8'h00);
    step("R3 lane6", 1'b1, 8'h00, 8'h00);
    step("R5 flush", 1'b0, 8'h00, 8'h00);
    step("R5 flush", 1'b0, 8'h00, 8'h00);

    // asynchronous reset mid-stream clears at once
    step("R1 load", 1'b1, 8'hFF, 8'hFF);
    step("R1 load", 1'b0, 8'h00, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async word", {16'd0, out_word}, 32'd0);
    check("R1 async valid", {31'd0, out_valid}, 32'd0);
    // inputs during first two edges after release are ignored
    in_valid = 1'b1; lane_rise = 8'hFF; lane_fall = 8'hFF;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 sync release valid", {31'd0, out_valid}, 32'd0);
    check("R1 sync release word", {16'd0, out_word}, 32'd0);
    in_valid = 1'b0; lane_rise = '0; lane_fall = '0;
    clear_model();
    step("R1 resume", 1'b0, '0, '0);
    step("R1 resume", 1'b0, '0, '0);
    step("R7 resume", 1'b1, 8'h3C, 8'hA5);
    step("R7 resume", 1'b1, 8'hA5, 8'h3C);
    step("R2 end", 1'b0, '0, '0);
    step("R2 end", 1'b0, '0, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule